// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the running time of day and calendar from a timekeeping core and compares it against two programmable alarm settings. On every seconds tick each alarm checks its unmasked fields against the current time. When all of those fields agree, the alarm raises a sticky flag. Software later clears the flag. Each flag drives an interrupt request only while that alarm's enable bit is set.

Alarm A has four fields: seconds, minutes, hours and a day field. Alarm B has no seconds setting and can only fire at second 00. Per-field mask bits choose how often each alarm fires, from every tick down to once a month or once a week. A select bit per alarm decides whether its day field is compared with the day of month or with the weekday. All values are BCD. Writes to the settings land on the clock edge. The comparison made in that same cycle still uses the old settings.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset both flags, both interrupt requests and both enable bits are 0, and all alarm fields, masks and select bits are 0.
- R2: An alarm is evaluated only in a cycle with `sec_tick` = 1. If every unmasked field matches in that cycle, its flag reads 1 from the next clock edge on. A matching time without a tick never sets a flag.
- R3: Alarm A with `a1_mask` = 4'b1111 sets its flag on every tick, whatever the time.
- R4: Mask bit order for alarm A: bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day field. For alarm B: bit 0 minutes, bit 1 hours, bit 2 day field. Pattern 4'b1110 on A compares seconds only; 4'b1100 adds minutes; 4'b1000 adds hours.
- R5: With the day field unmasked, select bit 0 compares it with `now_date` and select bit 1 compares it with `now_wday`. The other input is ignored.
- R6: Alarm B matches only on a tick with `now_sec` = 8'h00, plus its unmasked fields. With mask 3'b111 it fires once per minute.
- R7: A flag stays 1 until a cycle with its `flag_clr` bit set (bit 0 = A, bit 1 = B). After that cycle it reads 0.
- R8: A match on the same edge as a clear wins, and the flag stays 1.
- R9: `irq[i]` is 1 exactly when `flag[i]` and enable bit i are both 1. The enables load from `ie_d` on a cycle with `ie_wr` = 1.
- R10: Any mask pattern is legal and is applied field by field. Every unmasked field must match, including a higher unmasked field above a masked lower field.
- R11: A settings write in the same cycle as a tick takes effect only for later ticks. That tick is judged against the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse after each seconds update |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hr | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current weekday, BCD |
| now_date | input | 8 | Current day of month, BCD |
| a1_wr | input | 1 | Load alarm A settings |
| a1_sec | input | 8 | Alarm A seconds |
| a1_min | input | 8 | Alarm A minutes |
| a1_hr | input | 8 | Alarm A hours |
| a1_day | input | 8 | Alarm A day field (date or weekday) |
| a1_mask | input | 4 | Alarm A masks (bit0 sec, bit1 min, bit2 hr, bit3 day) |
| a1_dysel | input | 1 | Alarm A day select: 0 date, 1 weekday |
| a2_wr | input | 1 | Load alarm B settings |
| a2_min | input | 8 | Alarm B minutes |
| a2_hr | input | 8 | Alarm B hours |
| a2_day | input | 8 | Alarm B day field |
| a2_mask | input | 3 | Alarm B masks (bit0 min, bit1 hr, bit2 day) |
| a2_dysel | input | 1 | Alarm B day select: 0 date, 1 weekday |
| ie_wr | input | 1 | Load interrupt enables |
| ie_d | input | 2 | New enables (bit0 A, bit1 B) |
| flag_clr | input | 2 | Clear flag pulse (bit0 A, bit1 B) |
| flag | output | 2 | Sticky alarm flags |
| irq | output | 2 | Gated interrupt requests |

## Verification
Two pairs of functions can land in the same cycle: a match with a software clear of the same flag, and a settings write with a tick. The bench provokes both on purpose. It drives a matching tick together with a `flag_clr` pulse, and it loads new alarm fields in the very cycle a tick arrives. A behavioural reference model decides each outcome from the requirements: set wins over clear, and the tick sees the old settings. The flags and requests are compared with the model on every cycle, so an outcome that is off by a cycle is caught as well as a wrong one.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int FW = 8;   // BCD field width
  localparam int NF = 4;   // fields per alarm: sec, min, hr, day
  localparam int NA = 2;   // number of alarms

  typedef logic [FW-1:0] bcd_t;

  typedef struct packed {
    bcd_t dd;
    bcd_t hr;
    bcd_t mn;
    bcd_t sc;
  } stamp_t;

  // one field agrees when it is masked or equal
  function automatic logic field_ok(input logic msk, input bcd_t want, input bcd_t have);
    return msk | (want == have);
  endfunction

  // all four fields must agree; mask bit 0 sec, 1 min, 2 hr, 3 day
  function automatic logic stamp_ok(input logic [NF-1:0] msk, input stamp_t want,
                                    input stamp_t have);
    return field_ok(msk[0], want.sc, have.sc) &
           field_ok(msk[1], want.mn, have.mn) &
           field_ok(msk[2], want.hr, have.hr) &
           field_ok(msk[3], want.dd, have.dd);
  endfunction
endpackage

// File: rtl/alarm_unit.sv
module alarm_unit
  import cal_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  stamp_t        w_set,
  input  logic [NF-1:0] w_mask,
  input  logic          w_dysel,
  input  logic          tick,
  input  bcd_t          now_sc,
  input  bcd_t          now_mn,
  input  bcd_t          now_hr,
  input  bcd_t          now_wday,
  input  bcd_t          now_date,
  output logic          hit
);
  stamp_t        set_q;
  logic [NF-1:0] mask_q;
  logic          dysel_q;
  stamp_t        now_s;

  // settings registers (R1 reset to 0, R11 take effect after the edge)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= '0;
      mask_q  <= '0;
      dysel_q <= 1'b0;
    end else if (wr) begin
      set_q   <= w_set;
      mask_q  <= w_mask;
      dysel_q <= w_dysel;
    end
  end

  // current time as seen by this alarm; day select picks the top field (R5)
  always_comb begin
    now_s.sc = now_sc;
    now_s.mn = now_mn;
    now_s.hr = now_hr;
    now_s.dd = dysel_q ? now_wday : now_date;
  end

  // R2, R10: evaluated on a tick only, field by field
  assign hit = tick & stamp_ok(mask_q, set_q, now_s);

  p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !hit);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  // set has priority over clear (R8), sticky otherwise (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & ie;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(flag));
  p_rise_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [FW-1:0] now_sec,
  input  logic [FW-1:0] now_min,
  input  logic [FW-1:0] now_hr,
  input  logic [FW-1:0] now_wday,
  input  logic [FW-1:0] now_date,
  input  logic          a1_wr,
  input  logic [FW-1:0] a1_sec,
  input  logic [FW-1:0] a1_min,
  input  logic [FW-1:0] a1_hr,
  input  logic [FW-1:0] a1_day,
  input  logic [NF-1:0] a1_mask,
  input  logic          a1_dysel,
  input  logic          a2_wr,
  input  logic [FW-1:0] a2_min,
  input  logic [FW-1:0] a2_hr,
  input  logic [FW-1:0] a2_day,
  input  logic [NF-2:0] a2_mask,
  input  logic          a2_dysel,
  input  logic          ie_wr,
  input  logic [NA-1:0] ie_d,
  input  logic [NA-1:0] flag_clr,
  output logic [NA-1:0] flag,
  output logic [NA-1:0] irq
);
  logic [NA-1:0] ie_q;
  logic [NA-1:0] hit_w;
  stamp_t        a1_set, a2_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_wr) ie_q <= ie_d;
  end

  assign a1_set = '{dd: a1_day, hr: a1_hr, mn: a1_min, sc: a1_sec};
  // alarm B: seconds field fixed at 00 and never masked (R6)
  assign a2_set = '{dd: a2_day, hr: a2_hr, mn: a2_min, sc: '0};

  alarm_unit u_alm_a (
    .clk(clk), .rst_n(rst_n), .wr(a1_wr), .w_set(a1_set), .w_mask(a1_mask),
    .w_dysel(a1_dysel), .tick(sec_tick), .now_sc(now_sec), .now_mn(now_min),
    .now_hr(now_hr), .now_wday(now_wday), .now_date(now_date), .hit(hit_w[0])
  );

  alarm_unit u_alm_b (
    .clk(clk), .rst_n(rst_n), .wr(a2_wr), .w_set(a2_set), .w_mask({a2_mask, 1'b0}),
    .w_dysel(a2_dysel), .tick(sec_tick), .now_sc(now_sec), .now_mn(now_min),
    .now_hr(now_hr), .now_wday(now_wday), .now_date(now_date), .hit(hit_w[1])
  );

  for (genvar gi = 0; gi < NA; gi++) begin : g_flag
    alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hit(hit_w[gi]), .clr(flag_clr[gi]),
      .ie(ie_q[gi]), .flag(flag[gi]), .irq(irq[gi])
    );
  end

  p_ie_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ie_wr |=> (ie_q == $past(ie_d)));
  p_b_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w[1] |-> (now_sec == '0));
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flag) == '0);
endmodule

// File: tb/test_cal_alarm_cmp.sv
module test_cal_alarm_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hr = '0, now_wday = '0, now_date = '0;
  logic       a1_wr = 1'b0;
  logic [7:0] a1_sec = '0, a1_min = '0, a1_hr = '0, a1_day = '0;
  logic [3:0] a1_mask = '0;
  logic       a1_dysel = 1'b0;
  logic       a2_wr = 1'b0;
  logic [7:0] a2_min = '0, a2_hr = '0, a2_day = '0;
  logic [2:0] a2_mask = '0;
  logic       a2_dysel = 1'b0;
  logic       ie_wr = 1'b0;
  logic [1:0] ie_d = '0, flag_clr = '0;
  logic [1:0] flag, irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  cal_alarm_cmp i_cal_alarm_cmp (.*);

  // behavioural reference model
  int  m_set[2][4];   // [alarm][field: 0 sec 1 min 2 hr 3 day]
  bit  m_msk[2][4];
  bit  m_dy[2];
  bit  m_flag[2];
  bit  m_ie[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_set[a, f]) begin m_set[a][f] = 0; m_msk[a][f] = 0; end
      foreach (m_flag[a]) begin m_flag[a] = 0; m_ie[a] = 0; m_dy[a] = 0; end
    end else begin
      int  now[4];
      bit  fire[2];
      for (int a = 0; a < 2; a++) begin
        now[0] = now_sec; now[1] = now_min; now[2] = now_hr;
        now[3] = m_dy[a] ? int'(now_wday) : int'(now_date);
        fire[a] = sec_tick;
        for (int f = 0; f < 4; f++)
          if (!m_msk[a][f] && now[f] != m_set[a][f]) fire[a] = 0;
      end
      for (int a = 0; a < 2; a++) begin
        if (fire[a]) m_flag[a] = 1;
        else if (flag_clr[a]) m_flag[a] = 0;
      end
      if (ie_wr) begin m_ie[0] = ie_d[0]; m_ie[1] = ie_d[1]; end
      if (a1_wr) begin
        m_set[0][0] = a1_sec; m_set[0][1] = a1_min; m_set[0][2] = a1_hr; m_set[0][3] = a1_day;
        for (int f = 0; f < 4; f++) m_msk[0][f] = a1_mask[f];
        m_dy[0] = a1_dysel;
      end
      if (a2_wr) begin
        m_set[1][0] = 0; m_set[1][1] = a2_min; m_set[1][2] = a2_hr; m_set[1][3] = a2_day;
        m_msk[1][0] = 0;
        for (int f = 1; f < 4; f++) m_msk[1][f] = a2_mask[f-1];
        m_dy[1] = a2_dysel;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int a = 0; a < 2; a++) begin
        bit ei;
        ei = m_flag[a] & m_ie[a];
        n_cmp++;
        if (flag[a] !== m_flag[a] || irq[a] !== ei) begin
          n_bad++;
          $display("FAIL %s alarm%0d t=%0t flag=%b irq=%b expected flag=%b irq=%b",
                   req, a, $time, flag[a], irq[a], m_flag[a], ei);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tk(input logic [7:0] s, m, h, w, d, input logic [1:0] clr = 2'b00);
    now_sec = s; now_min = m; now_hr = h; now_wday = w; now_date = d;
    sec_tick = 1'b1; flag_clr = clr;
    cyc();
    sec_tick = 1'b0; flag_clr = 2'b00;
  endtask

  task automatic wa(input logic [7:0] s, m, h, d, input logic [3:0] mk, input logic dy);
    a1_sec = s; a1_min = m; a1_hr = h; a1_day = d; a1_mask = mk; a1_dysel = dy;
    a1_wr = 1'b1; cyc(); a1_wr = 1'b0;
  endtask

  task automatic wb(input logic [7:0] m, h, d, input logic [2:0] mk, input logic dy);
    a2_min = m; a2_hr = h; a2_day = d; a2_mask = mk; a2_dysel = dy;
    a2_wr = 1'b1; cyc(); a2_wr = 1'b0;
  endtask

  task automatic clr(input logic [1:0] b);
    flag_clr = b; cyc(); flag_clr = 2'b00;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    req = "R1";
    n_cmp++;
    if (flag !== 2'b00 || irq !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 flag=%b irq=%b expected 00 00", flag, irq);
    end
    tk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);  // all settings 0, masks 0: no match
    // R9: enables
    req = "R9";
    ie_wr = 1'b1; ie_d = 2'b11; cyc(); ie_wr = 1'b0;
    // R3: every second
    req = "R3";
    wa(8'h00, 8'h00, 8'h00, 8'h00, 4'b1111, 1'b0);
    tk(8'h17, 8'h22, 8'h09, 8'h02, 8'h11);
    cyc();
    clr(2'b01);
    tk(8'h18, 8'h22, 8'h09, 8'h02, 8'h11);
    clr(2'b11);
    // R2: seconds only, tick gating
    req = "R2";
    wa(8'h30, 8'h00, 8'h00, 8'h00, 4'b1110, 1'b0);
    tk(8'h29, 8'h00, 8'h00, 8'h01, 8'h01);
    now_sec = 8'h30; cyc(); cyc();          // matching time, no tick
    tk(8'h30, 8'h45, 8'h12, 8'h01, 8'h01);
    clr(2'b01);
    // R4: minutes+seconds, then hours too
    req = "R4";
    wa(8'h10, 8'h20, 8'h00, 8'h00, 4'b1100, 1'b0);
    tk(8'h10, 8'h21, 8'h05, 8'h01, 8'h01);
    tk(8'h10, 8'h20, 8'h05, 8'h01, 8'h01);
    clr(2'b01);
    wa(8'h10, 8'h20, 8'h07, 8'h00, 4'b1000, 1'b0);
    tk(8'h10, 8'h20, 8'h06, 8'h01, 8'h01);
    tk(8'h10, 8'h20, 8'h07, 8'h01, 8'h01);
    clr(2'b01);
    // R5: date vs weekday
    req = "R5";
    wa(8'h00, 8'h30, 8'h08, 8'h15, 4'b0000, 1'b0);
    tk(8'h00, 8'h30, 8'h08, 8'h15, 8'h14);  // weekday equals, date differs
    tk(8'h00, 8'h30, 8'h08, 8'h03, 8'h15);
    clr(2'b01);
    wa(8'h00, 8'h30, 8'h08, 8'h05, 4'b0000, 1'b1);
    tk(8'h00, 8'h30, 8'h08, 8'h04, 8'h05);  // date equals, weekday differs
    tk(8'h00, 8'h30, 8'h08, 8'h05, 8'h22);
    clr(2'b01);
    // R6: alarm B needs second 00
    req = "R6";
    wa(8'h00, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0);
    wb(8'h00, 8'h00, 8'h00, 3'b111, 1'b0);
    tk(8'h01, 8'h11, 8'h02, 8'h03, 8'h04);
    tk(8'h59, 8'h11, 8'h02, 8'h03, 8'h04);
    tk(8'h00, 8'h12, 8'h02, 8'h03, 8'h04);
    clr(2'b10);
    wb(8'h42, 8'h00, 8'h00, 3'b110, 1'b0);
    tk(8'h00, 8'h41, 8'h02, 8'h03, 8'h04);
    tk(8'h05, 8'h42, 8'h02, 8'h03, 8'h04);
    tk(8'h00, 8'h42, 8'h02, 8'h03, 8'h04);
    clr(2'b10);
    wb(8'h42, 8'h23, 8'h06, 3'b000, 1'b1);
    tk(8'h00, 8'h42, 8'h23, 8'h05, 8'h06);
    tk(8'h00, 8'h42, 8'h23, 8'h06, 8'h05);
    // R8: set wins over clear on the same edge
    req = "R8";
    tk(8'h00, 8'h42, 8'h23, 8'h06, 8'h05, 2'b10);
    cyc();
    // R7: clear only when asked, sticky otherwise
    req = "R7";
    tk(8'h01, 8'h42, 8'h23, 8'h06, 8'h05);
    cyc(); cyc();
    clr(2'b10);
    // R9: enables gate the request
    req = "R9";
    wa(8'h00, 8'h00, 8'h00, 8'h00, 4'b1111, 1'b0);
    ie_wr = 1'b1; ie_d = 2'b10; cyc(); ie_wr = 1'b0;
    tk(8'h33, 8'h00, 8'h00, 8'h01, 8'h01);
    cyc();
    ie_wr = 1'b1; ie_d = 2'b01; cyc(); ie_wr = 1'b0;
    cyc();
    clr(2'b11);
    // R10: odd pattern, day and minutes unmasked, seconds and hours masked
    req = "R10";
    wa(8'h00, 8'h15, 8'h00, 8'h09, 4'b0101, 1'b0);
    tk(8'h44, 8'h15, 8'h13, 8'h01, 8'h08);
    tk(8'h44, 8'h16, 8'h13, 8'h01, 8'h09);
    tk(8'h44, 8'h15, 8'h13, 8'h01, 8'h09);
    clr(2'b01);
    // R11: write on the tick cycle uses old settings
    req = "R11";
    wa(8'h50, 8'h00, 8'h00, 8'h00, 4'b1110, 1'b0);
    a1_sec = 8'h20; a1_mask = 4'b1110; a1_wr = 1'b1;
    now_sec = 8'h20; sec_tick = 1'b1;      // would match only new settings
    cyc();
    a1_wr = 1'b0; sec_tick = 1'b0;
    tk(8'h20, 8'h00, 8'h00, 8'h01, 8'h01);
    clr(2'b01);
    a1_sec = 8'h05; a1_wr = 1'b1;
    now_sec = 8'h20; sec_tick = 1'b1;      // matches only old settings
    cyc();
    a1_wr = 1'b0; sec_tick = 1'b0;
    cyc();
    clr(2'b01);
    repeat (3) cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule